// File: doc/BRIEF.md
# Pairwise Widening Vector Adder

This unit takes a 128-bit source vector and treats it as packed narrow elements of 8, 16 or 32 bits. It adds each adjacent pair of elements into one result element of twice the width, so the result has half as many lanes as the source. The unit can return that sum as it is, or add it to the matching wide lane of a supplied destination vector, with wraparound at the wide lane width.

A control input picks whether the narrow elements are sign-extended or zero-extended before the pair is added. A second control limits the operation to the low 64 bits of the vector. One request is taken on each cycle that the valid strobe is high. The result and a matching valid flag appear one clock later. The size code 11, which would mean 64-bit source elements, is refused. In that case the unit raises an error flag and drives an all-zero result instead of computing one.

Top module: `pairwise_widen_add`

## Requirements
- R1: Size code 00 takes 8-bit source elements. Wide lane i (16 bits, at bits [16i+15:16i]) equals the extended byte at [16i+7:16i] plus the extended byte at [16i+15:16i+8].
- R2: Size code 01 takes 16-bit source elements and forms four 32-bit lanes. Lane i occupies bits [32i+31:32i] and is the sum of its two extended 16-bit halves.
- R3: Size code 10 takes 32-bit source elements and forms two 64-bit lanes. Each lane is the sum of the low and high 32-bit halves at the same position.
- R4: When is_signed is 1, each narrow element is sign-extended to the wide width before the add. The most negative elements of a pair therefore give the most negative even sum.
- R5: When is_signed is 0, each narrow element is zero-extended before the add.
- R6: When accumulate is 1, the pair sum is added to the destination lane at the same position, modulo 2^(wide width). When accumulate is 0, dst_vec has no effect on the result.
- R7: No carry crosses from one wide lane into the next, either in the pair sum or in the accumulate.
- R8: Size code 11 is illegal. The registered result has out_illegal = 1 and out_vec = 0, whatever the other inputs are. Every legal code gives out_illegal = 0.
- R9: When half_width is 1, out_vec[127:64] is zero and out_vec[63:0] holds the normal lanes for the low 64 source bits.
- R10: A request with in_valid = 1 at a rising edge is registered on that edge. out_valid is then 1 for exactly that following cycle, and is 0 after any edge with in_valid = 0.
- R11: out_vec and out_illegal keep their values across edges where in_valid is 0.
- R12: A synchronous active-high reset clears out_valid, out_illegal and out_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 128 | Packed narrow source elements |
| dst_vec | input | 128 | Current destination vector, used when accumulating |
| elem_size | input | 2 | Source element size: 00 = 8, 01 = 16, 10 = 32, 11 = illegal |
| is_signed | input | 1 | 1 = sign-extend elements, 0 = zero-extend |
| accumulate | input | 1 | 1 = add the pair sums into dst_vec lanes |
| half_width | input | 1 | 1 = operate on the low 64 bits only |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_vec | output | 128 | New destination vector |
| out_illegal | output | 1 | Request carried size code 11 |

## Verification
A wrong size decode or a wrong extension sign corrupts whole lanes of out_vec. The damage shows in the cycle right after the strobe, so every request is compared against an independent lane-by-lane model. A carry that leaks between lanes only appears when the operands are at their extremes, so the pattern table includes all-ones and the most negative and largest values. A fault in the result register shows either as a valid flag that lasts the wrong number of cycles or as out_vec changing between requests. Both are checked one and two cycles after each strobe.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
    localparam int VEC_BITS  = 128;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } elem_size_e;

    typedef struct packed {
        logic                illegal;
        logic [VEC_BITS-1:0] vec;
    } pwa_result_t;

    function automatic int narrow_of(input int k);
        return 8 << k;
    endfunction
endpackage

// File: rtl/pwa_lane.sv
module pwa_lane #(
    parameter int NARROW = 8,
    localparam int WIDE = 2 * NARROW
) (
    input  logic [WIDE-1:0] pair,
    input  logic [WIDE-1:0] acc_in,
    input  logic            is_signed,
    input  logic            accumulate,
    output logic [WIDE-1:0] sum
);
    logic [WIDE-1:0] lo_ext, hi_ext, pair_sum;
    logic            lo_fill, hi_fill;

    always_comb begin
        lo_fill  = is_signed & pair[NARROW-1];
        hi_fill  = is_signed & pair[WIDE-1];
        lo_ext   = {{NARROW{lo_fill}}, pair[NARROW-1:0]};
        hi_ext   = {{NARROW{hi_fill}}, pair[WIDE-1:NARROW]};
        pair_sum = lo_ext + hi_ext;
        sum      = pair_sum + (accumulate ? acc_in : '0);
    end

    // R5
    always_comb begin
        if (!$isunknown({pair, is_signed, accumulate}) && !is_signed && !accumulate)
            unsigned_range_chk: assert (!sum[WIDE-1]);
    end
endmodule

// File: rtl/pwa_bank.sv
module pwa_bank #(
    parameter int VEC_W  = 128,
    parameter int NARROW = 8,
    localparam int WIDE  = 2 * NARROW,
    localparam int LANES = VEC_W / WIDE
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst,
    input  logic             is_signed,
    input  logic             accumulate,
    output logic [VEC_W-1:0] result
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pwa_lane #(.NARROW(NARROW)) u_lane (
            .pair       (src[i*WIDE +: WIDE]),
            .acc_in     (dst[i*WIDE +: WIDE]),
            .is_signed  (is_signed),
            .accumulate (accumulate),
            .sum        (result[i*WIDE +: WIDE])
        );
    end
endmodule

// File: rtl/pairwise_widen_add.sv
module pairwise_widen_add
    import pwa_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [VEC_BITS-1:0] src_vec,
    input  logic [VEC_BITS-1:0] dst_vec,
    input  logic [1:0]          elem_size,
    input  logic                is_signed,
    input  logic                accumulate,
    input  logic                half_width,
    output logic                out_valid,
    output logic [VEC_BITS-1:0] out_vec,
    output logic                out_illegal
);
    localparam int HALF = VEC_BITS / 2;

    logic [VEC_BITS-1:0] bank_out [NUM_SIZES];
    pwa_result_t         nxt, cur;
    elem_size_e          size_sel;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_bank
        pwa_bank #(.VEC_W(VEC_BITS), .NARROW(narrow_of(k))) u_bank (
            .src        (src_vec),
            .dst        (dst_vec),
            .is_signed  (is_signed),
            .accumulate (accumulate),
            .result     (bank_out[k])
        );
    end

    always_comb begin
        size_sel    = elem_size_e'(elem_size);
        nxt.illegal = 1'b0;
        unique case (size_sel)
            SZ_BYTE: nxt.vec = bank_out[0];
            SZ_HALF: nxt.vec = bank_out[1];
            SZ_WORD: nxt.vec = bank_out[2];
            default: begin
                nxt.vec     = '0;
                nxt.illegal = 1'b1;
            end
        endcase
        if (half_width) nxt.vec[HALF +: HALF] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) cur <= nxt;
        end
    end

    assign out_vec     = cur.vec;
    assign out_illegal = cur.illegal;

    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_size == 2'b11) |=> (out_illegal && out_vec == '0));
    // R9
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && half_width) |=> (out_vec[VEC_BITS-1:HALF] == '0));
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_vec) && $stable(out_illegal)));
endmodule

// File: tb/pairwise_widen_add_bench.sv
module pairwise_widen_add_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_vec = '0, dst_vec = '0;
    logic [1:0]   elem_size = 2'b00;
    logic         is_signed = 1'b0, accumulate = 1'b0, half_width = 1'b0;
    logic         out_valid, out_illegal;
    logic [127:0] out_vec;
    int           errors = 0, checks = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    pairwise_widen_add u_pairwise_widen_add (
        .clk, .rst, .in_valid, .src_vec, .dst_vec, .elem_size,
        .is_signed, .accumulate, .half_width,
        .out_valid, .out_vec, .out_illegal
    );

    localparam logic [127:0] SRC_TAB [6] = '{
        128'h8080_8080_8080_8080_8080_8080_8080_8080,
        128'h7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F_7F7F,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h8000_0000_8000_0000_7FFF_FFFF_7FFF_FFFF,
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'h8000_7FFF_0001_FFFF_8000_8000_7FFF_7FFF
    };
    localparam logic [127:0] DST_TAB [6] = '{
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h0000_0000_0000_0000_0000_0000_0000_0000,
        128'h0001_0001_0001_0001_0001_0001_0001_0001,
        128'h7FFF_FFFF_FFFF_FFFF_8000_0000_0000_0000,
        128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0,
        128'hFFFF_0000_FFFF_0000_8000_7FFF_0000_FFFF
    };

    function automatic logic [63:0] lmask(input int n);
        return (n >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
    endfunction

    function automatic logic [127:0] ref_calc(input logic [127:0] s, input logic [127:0] d,
                                              input int sz, input bit sgn, input bit acc,
                                              input bit hw);
        int n = 8 << sz;
        int w = 2 * n;
        logic [127:0] r = '0;
        if (sz == 3) return '0;
        for (int i = 0; i < 128 / w; i++) begin
            logic [63:0] a, b, c, t;
            a = 64'(s >> (i * w)) & lmask(n);
            b = 64'(s >> (i * w + n)) & lmask(n);
            c = 64'(d >> (i * w)) & lmask(w);
            if (sgn && a[n-1]) a = a | ~lmask(n);
            if (sgn && b[n-1]) b = b | ~lmask(n);
            t = a + b + (acc ? c : 64'd0);
            r = r | (128'(t & lmask(w)) << (i * w));
        end
        if (hw) r[127:64] = '0;
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [127:0] s, input logic [127:0] d, input logic [1:0] sz,
                         input bit sgn, input bit acc, input bit hw);
        @(negedge clk);
        src_vec = s; dst_vec = d; elem_size = sz;
        is_signed = sgn; accumulate = acc; half_width = hw; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 valid", 128'(out_valid), 128'd0);
        check("R12 illegal", 128'(out_illegal), 128'd0);
        check("R12 vec", out_vec, '0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6 R7 R9 table walk
        for (int t = 0; t < 6; t++)
            for (int sz = 0; sz < 3; sz++)
                for (int m = 0; m < 8; m++) begin
                    issue(SRC_TAB[t], DST_TAB[t], 2'(sz), m[0], m[1], m[2]);
                    check(sz == 0 ? "R1/R4/R5/R6/R7" : sz == 1 ? "R2/R4/R5/R6/R7" : "R3/R4/R5/R6/R7",
                          out_vec, ref_calc(SRC_TAB[t], DST_TAB[t], sz, m[0], m[1], m[2]));
                    check("R8 legal flag", 128'(out_illegal), 128'd0);
                    check("R10 valid", 128'(out_valid), 128'd1);
                end

        // R4 most negative bytes signed: each lane 0xFF00
        issue({16{8'h80}}, '0, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R4 min pair", out_vec, {8{16'hFF00}});
        // R5 max bytes unsigned: each lane 0x01FE
        issue({16{8'hFF}}, '0, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R5 max pair", out_vec, {8{16'h01FE}});
        // R7 accumulate wrap must not carry into neighbour lane
        issue({16{8'hFF}}, {8{16'hFFFF}}, 2'b00, 1'b0, 1'b1, 1'b0);
        check("R7 lane wrap", out_vec, {8{16'h01FD}});
        // R3 word signed: 0x80000000 + 0x80000000 = -2^32
        issue({4{32'h8000_0000}}, '0, 2'b10, 1'b1, 1'b0, 1'b0);
        check("R3 word min", out_vec, {2{64'hFFFF_FFFF_0000_0000}});
        // R6 dst ignored without accumulate
        issue({16{8'h01}}, {16{8'hA5}}, 2'b00, 1'b0, 1'b0, 1'b0);
        check("R6 dst ignored", out_vec, {8{16'h0002}});
        // R9 half width
        issue({16{8'h01}}, '0, 2'b00, 1'b0, 1'b0, 1'b1);
        check("R9 half", out_vec, {64'd0, {4{16'h0002}}});

        // R8 illegal size
        issue({16{8'h11}}, {16{8'h22}}, 2'b11, 1'b1, 1'b1, 1'b0);
        check("R8 illegal flag", 128'(out_illegal), 128'd1);
        check("R8 illegal vec", out_vec, '0);
        check("R10 valid illegal", 128'(out_valid), 128'd1);
        @(negedge clk);
        check("R10 valid drop", 128'(out_valid), 128'd0);

        // R11 hold across idle cycles with changing inputs
        issue({16{8'h03}}, '0, 2'b00, 1'b0, 1'b0, 1'b0);
        src_vec = '1; elem_size = 2'b11;
        repeat (3) @(negedge clk);
        check("R11 hold vec", out_vec, {8{16'h0006}});
        check("R11 hold flag", 128'(out_illegal), 128'd0);
        check("R10 idle valid", 128'(out_valid), 128'd0);

        // R12 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R12 vec after reset", out_vec, '0);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule